// File: doc/BRIEF.md
# Synchronisation Pulse Generator

This block produces an alignment pulse train used to line up several converters or other devices on a shared timing event. It runs on the device clock. Each pulse period is a programmable whole number of device clocks, and each pulse is high for half of that period. A request starts generation. The request is the OR of a pin and a register bit, and the block synchronises it internally.

One input selects how a request is served. It can produce one pulse, a programmed number of pulses, or a train that continues while the request stays high. The period and the count are captured when a burst starts. A busy output shows that a burst is in progress, so software or a sequencer can wait for it to finish before asking again.

Top module: `spg_top`

## Requirements
- R1: While reset is high, and on the first clock after it, `pulse_out` and `busy` are low.
- R2: The request seen by the block is `req_pin` OR `req_reg`. It passes through a two-flop synchroniser and is edge-detected, so only a low-to-high change starts a burst. If the request line rises before a clock edge, `pulse_out` goes high after the third rising clock edge, counting that edge as the first.
- R3: The effective period P is the `period` input, with values below 2 treated as 2. Each pulse is high for floor(P/2) clocks, and pulse starts within a burst are P clocks apart.
- R4: Mode code 0 (single) emits exactly one pulse per request.
- R5: Mode code 1 (multi) emits `shots` pulses per request, with a count of 0 treated as 1.
- R6: Mode code 2 (continuous) emits pulses until the synchronised request is low or the mode input is no longer 2. If the train is stopped during the high phase, that high phase completes and the burst ends. If it is stopped during the low phase, the burst ends at the end of that period.
- R7: Mode code 3 (off) starts nothing; requests have no effect on the outputs.
- R8: A request edge that arrives while `busy` is high is ignored. This includes an edge in the cycle in which the final pulse ends.
- R9: `busy` goes high in the same cycle as the first pulse. In single and multi modes it falls in the cycle after the last pulse's high phase. `pulse_out` is never high without `busy`.
- R10: `period`, `shots` and the burst kind are captured at burst start. Changing `period` or `shots` during a burst does not change that burst.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Device clock |
| rst | input | 1 | Synchronous active-high reset |
| mode | input | 2 | 0 single, 1 multi, 2 continuous, 3 off |
| shots | input | CNT_W | Pulse count for multi mode |
| period | input | DIV_W | Pulse period in device clocks |
| req_pin | input | 1 | Asynchronous request pin |
| req_reg | input | 1 | Request control bit |
| pulse_out | output | 1 | Alignment pulse |
| busy | output | 1 | Burst in progress |

## Verification
Two events can fall in the same clock cycle. The first pair is a new synchronised request edge and the end of a burst's last high phase. The bench provokes it by sweeping the delay of a second request across the tail of a multi-pulse burst. The second pair is a continuous-mode stop and a phase boundary (high-phase end or period wrap). The bench sweeps the moment the request drops, and separately the moment the mode changes. In both sweeps a behavioural reference model judges every clock: whether the second request was ignored, and in which cycle the train ended.

// File: rtl/spg_pkg.sv
package spg_pkg;

    typedef enum logic [1:0] {
        SPG_ONE   = 2'd0,
        SPG_MULTI = 2'd1,
        SPG_RUN   = 2'd2,
        SPG_OFF   = 2'd3
    } spg_mode_e;

    localparam int SPG_MIN_PERIOD = 2;

    function automatic logic spg_can_start(spg_mode_e m);
        return m != SPG_OFF;
    endfunction

    function automatic logic spg_is_run(spg_mode_e m);
        return m == SPG_RUN;
    endfunction

endpackage

// File: rtl/spg_req_sync.sv
module spg_req_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic req_in,
    output logic req_level,
    output logic req_rise
);
    localparam int TOP = STAGES - 1;

    logic [STAGES-1:0] chain_q;
    logic              prev_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            chain_q <= '0;
            prev_q  <= 1'b0;
        end else begin
            chain_q <= {chain_q[STAGES-2:0], req_in};
            prev_q  <= chain_q[TOP];
        end
    end

    assign req_level = chain_q[TOP];
    assign req_rise  = chain_q[TOP] & ~prev_q;

endmodule

// File: rtl/spg_burst_ctrl.sv
module spg_burst_ctrl
    import spg_pkg::*;
#(
    parameter int CNT_W = 8,
    parameter int DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  spg_mode_e        mode,
    input  logic [CNT_W-1:0] shots,
    input  logic [DIV_W-1:0] period,
    input  logic             req_level,
    input  logic             req_rise,
    output logic             pulse,
    output logic             active
);
    localparam logic [DIV_W-1:0] PMIN = DIV_W'(SPG_MIN_PERIOD);
    localparam logic [DIV_W-1:0] D1   = DIV_W'(1);
    localparam logic [CNT_W-1:0] C1   = CNT_W'(1);

    typedef struct packed {
        logic             run;
        logic             cont;
        logic [DIV_W-1:0] per;
        logic [DIV_W-1:0] phase;
        logic [CNT_W-1:0] left;
    } burst_t;

    burst_t st_q, st_d;

    logic [DIV_W-1:0] hi_len;
    logic             at_hi_end, at_wrap, run_stop, last_shot;

    assign hi_len    = st_q.per >> 1;
    assign at_hi_end = st_q.phase == hi_len - D1;
    assign at_wrap   = st_q.phase == st_q.per - D1;
    assign run_stop  = st_q.cont && (!spg_is_run(mode) || !req_level);
    assign last_shot = !st_q.cont && at_hi_end && st_q.left == C1;

    always_comb begin
        st_d = st_q;
        if (!st_q.run) begin
            if (req_rise && spg_can_start(mode)) begin
                st_d.run   = 1'b1;
                st_d.cont  = spg_is_run(mode);
                st_d.phase = '0;
                st_d.per   = (period < PMIN) ? PMIN : period;
                unique case (mode)
                    SPG_MULTI: st_d.left = (shots == '0) ? C1 : shots;
                    default:   st_d.left = C1;
                endcase
            end
        end else if (last_shot || (run_stop && (at_hi_end || at_wrap))) begin
            st_d.run = 1'b0;
        end else begin
            if (!st_q.cont && at_hi_end) begin
                st_d.left = st_q.left - C1;
            end
            st_d.phase = at_wrap ? '0 : st_q.phase + D1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign pulse  = st_q.run && (st_q.phase < hi_len);
    assign active = st_q.run;

endmodule

// File: rtl/spg_top.sv
module spg_top
    import spg_pkg::*;
#(
    parameter int CNT_W       = 8,
    parameter int DIV_W       = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [1:0]       mode,
    input  logic [CNT_W-1:0] shots,
    input  logic [DIV_W-1:0] period,
    input  logic             req_pin,
    input  logic             req_reg,
    output logic             pulse_out,
    output logic             busy
);
    logic req_level, req_rise;

    spg_req_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk       (clk),
        .rst       (rst),
        .req_in    (req_pin | req_reg),
        .req_level (req_level),
        .req_rise  (req_rise)
    );

    spg_burst_ctrl #(.CNT_W(CNT_W), .DIV_W(DIV_W)) u_ctrl (
        .clk       (clk),
        .rst       (rst),
        .mode      (spg_mode_e'(mode)),
        .shots     (shots),
        .period    (period),
        .req_level (req_level),
        .req_rise  (req_rise),
        .pulse     (pulse_out),
        .active    (busy)
    );

endmodule

// File: rtl/spg_checker.sv
module spg_checker (
    input logic       clk,
    input logic       rst,
    input logic [1:0] mode,
    input logic       req_rise,
    input logic       pulse_out,
    input logic       busy
);
    // R1
    a_r1_reset_quiet: assert property (@(posedge clk)
        rst |=> (!busy && !pulse_out));

    // R9
    a_r9_pulse_in_busy: assert property (@(posedge clk) disable iff (rst)
        pulse_out |-> busy);

    // R9
    a_r9_busy_starts_with_pulse: assert property (@(posedge clk) disable iff (rst)
        $rose(busy) |-> pulse_out);

    // R2
    a_r2_start_needs_edge: assert property (@(posedge clk) disable iff (rst)
        $rose(busy) |-> $past(req_rise));

    // R7
    a_r7_off_stays_idle: assert property (@(posedge clk) disable iff (rst)
        (mode == 2'd3 && !busy) |=> !busy);

    // R9: a burst ends only after a high phase or a period end, never mid-pulse
    a_r9_end_not_mid_pulse: assert property (@(posedge clk) disable iff (rst)
        ($fell(busy) && $past(pulse_out, 2)) |-> $past(pulse_out));

endmodule

bind spg_top spg_checker u_chk (
    .clk       (clk),
    .rst       (rst),
    .mode      (mode),
    .req_rise  (req_rise),
    .pulse_out (pulse_out),
    .busy      (busy)
);

// File: tb/tb_spg_top.sv
module tb_spg_top;
    localparam int CNT_W = 8;
    localparam int DIV_W = 8;

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic [1:0]       mode = 2'd0;
    logic [CNT_W-1:0] shots = '0;
    logic [DIV_W-1:0] period = DIV_W'(6);
    logic             req_pin = 1'b0;
    logic             req_reg = 1'b0;
    logic             pulse_out, busy;

    spg_top #(.CNT_W(CNT_W), .DIV_W(DIV_W)) dut (
        .clk(clk), .rst(rst), .mode(mode), .shots(shots), .period(period),
        .req_pin(req_pin), .req_reg(req_reg), .pulse_out(pulse_out), .busy(busy)
    );

    always #5 clk = ~clk;

    int    vectors = 0;
    int    errors  = 0;
    string tag     = "R1";
    bit    cmp_en  = 1'b0;
    bit    done    = 1'b0;

    // behavioural reference model
    int m_s1 = 0, m_s2 = 0, m_s3 = 0;
    int m_run = 0, m_ph = 0, m_per = 2, m_left = 0, m_cont = 0;

    always @(posedge clk) begin : ref_model
        int rise, lvl, hi;
        if (rst) begin
            m_s1 = 0; m_s2 = 0; m_s3 = 0;
            m_run = 0; m_ph = 0; m_per = 2; m_left = 0; m_cont = 0;
        end else begin
            rise = (m_s2 == 1 && m_s3 == 0) ? 1 : 0;
            lvl  = m_s2;
            if (m_run == 0) begin
                if (rise == 1 && mode != 2'd3) begin
                    m_run  = 1;
                    m_ph   = 0;
                    m_per  = (int'(period) < 2) ? 2 : int'(period);
                    m_cont = (mode == 2'd2) ? 1 : 0;
                    if (mode == 2'd1) m_left = (shots == 0) ? 1 : int'(shots);
                    else              m_left = 1;
                end
            end else begin
                hi = m_per / 2;
                if (m_cont == 0 && m_ph == hi - 1 && m_left == 1)
                    m_run = 0;
                else if (m_cont == 1 && (mode != 2'd2 || lvl == 0) &&
                         (m_ph == hi - 1 || m_ph == m_per - 1))
                    m_run = 0;
                else begin
                    if (m_cont == 0 && m_ph == hi - 1) m_left = m_left - 1;
                    m_ph = (m_ph == m_per - 1) ? 0 : m_ph + 1;
                end
            end
            m_s3 = m_s2;
            m_s2 = m_s1;
            m_s1 = (req_pin | req_reg) ? 1 : 0;
        end
    end

    task automatic check_bit(input string req, input logic act, input logic exp);
        vectors++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0b expected=%0b at %0t", req, act, exp, $time);
        end
    endtask

    task automatic check_int(input string req, input int act, input int exp);
        vectors++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
        end
    endtask

    always @(negedge clk) begin
        if (cmp_en && !done) begin
            check_bit({tag, " pulse_out"}, pulse_out,
                      (m_run == 1 && m_ph < m_per / 2) ? 1'b1 : 1'b0);
            check_bit({tag, " busy"}, busy, m_run == 1 ? 1'b1 : 1'b0);
        end
    end

    int   rises  = 0;
    logic prev_p = 1'b0;
    always @(negedge clk) begin
        if (pulse_out === 1'b1 && prev_p === 1'b0) rises <= rises + 1;
        prev_p <= pulse_out;
    end

    task automatic cycles(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic fire(input bit use_reg);
        if (use_reg) req_reg = 1'b1; else req_pin = 1'b1;
        cycles(2);
        req_reg = 1'b0;
        req_pin = 1'b0;
    endtask

    task automatic burst(input string t, input logic [1:0] md, input int n, input int p,
                         input bit use_reg, input int wait_n, input int exp_pulses);
        tag    = t;
        mode   = md;
        shots  = CNT_W'(n);
        period = DIV_W'(p);
        @(negedge clk);
        rises = 0;
        fire(use_reg);
        cycles(wait_n);
        check_int({t, " pulse count"}, rises, exp_pulses);
        check_bit({t, " idle after burst"}, busy, 1'b0);
    endtask

    initial begin : watchdog
        #(200000 * 10);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
            $finish;
        end
    end

    initial begin : stim
        cycles(3);
        cmp_en = 1'b1;
        check_bit("R1 pulse in reset", pulse_out, 1'b0);
        check_bit("R1 busy in reset", busy, 1'b0);
        rst = 1'b0;
        @(negedge clk);
        check_bit("R1 pulse after reset", pulse_out, 1'b0);
        check_bit("R1 busy after reset", busy, 1'b0);

        // R2 latency, R4 single pulse via pin
        tag = "R2"; mode = 2'd0; period = DIV_W'(6);
        rises = 0;
        req_pin = 1'b1;
        @(negedge clk); check_bit("R2 edge 1", pulse_out, 1'b0);
        @(negedge clk); check_bit("R2 edge 2", pulse_out, 1'b0);
        @(negedge clk); check_bit("R2 edge 3", pulse_out, 1'b1);
        cycles(3);      check_bit("R3 high length 3", pulse_out, 1'b0);
        cycles(15);     req_pin = 1'b0;
        check_int("R4 single with held request", rises, 1);
        cycles(5);

        burst("R4", 2'd0, 0, 7, 1'b1, 20, 1);
        burst("R5", 2'd1, 4, 4, 1'b0, 30, 4);
        burst("R5", 2'd1, 0, 3, 1'b1, 15, 1);
        burst("R7", 2'd3, 2, 4, 1'b0, 20, 0);
        burst("R3", 2'd1, 2, 0, 1'b0, 15, 2);
        burst("R3", 2'd1, 3, 9, 1'b1, 40, 3);

        // R8: request mid-burst ignored
        tag = "R8"; mode = 2'd1; shots = CNT_W'(3); period = DIV_W'(8);
        rises = 0;
        fire(1'b0); cycles(5); fire(1'b1); cycles(40);
        check_int("R8 mid-burst request ignored", rises, 3);

        // R8: sweep second request across the burst tail
        for (int off = 12; off < 26; off++) begin
            tag = "R8";
            fire(1'b0); cycles(off); fire(1'b0); cycles(45);
        end

        // R10: settings change during a burst
        tag = "R10"; mode = 2'd1; shots = CNT_W'(3); period = DIV_W'(6);
        @(negedge clk); rises = 0;
        fire(1'b0); cycles(4);
        period = DIV_W'(2); shots = CNT_W'(9);
        cycles(30);
        check_int("R10 latched count", rises, 3);

        // R6: continuous, stopped by request drop at swept times
        for (int hold = 10; hold < 21; hold++) begin
            tag = "R6"; mode = 2'd2; period = DIV_W'(5);
            @(negedge clk); rises = 0;
            req_pin = 1'b1; cycles(hold); req_pin = 1'b0;
            cycles(12);
            check_bit("R6 train stopped after drop", busy, 1'b0);
            check_int("R6 pulses within hold", (rises > 0) ? 1 : 0, 1);
        end

        // R6: continuous, stopped by mode change while request held
        for (int hold = 9; hold < 15; hold++) begin
            tag = "R6"; mode = 2'd2; period = DIV_W'(6);
            req_reg = 1'b1; cycles(hold);
            mode = 2'd0; cycles(10);
            rises = 0;
            check_bit("R6 mode change stops train", busy, 1'b0);
            cycles(8);
            check_int("R6 no pulse after mode change", rises, 0);
            req_reg = 1'b0; cycles(4);
        end

        cycles(4);
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end

endmodule